// File: doc/BRIEF.md
# Tagged Serial Byte Receiver

This block is the write-only serial input port of a display controller. A host drives four lines: a serial clock, a serial data line, an active-low chip select and a register-select line. While chip select is low, the block takes one data bit on every rising edge of the serial clock. Bits arrive most significant first. On the eighth rising edge it hands the finished byte to the controller core as a parallel word.

Each byte carries a tag bit. The tag is the level of the register-select line at the eighth bit. Low marks display memory data and high marks a command register write. All four host lines are asynchronous to the system clock, so they pass through synchronizers first. The serial clock edge is then found by oversampling in the system clock domain. The system clock must run at least eight times faster than the serial clock. The host's serial clock period is at least 1000 ns, with each phase at least 400 ns.

Raising chip select throws away any partial byte. Framing always restarts cleanly at the next selection. There is no read path.

Top module: `tagged_serial_rx`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first byte completes, `byte_o`, `tag_o` and `valid_o` are all 0.
- R2: Bits are assembled in the order they arrive. The first bit becomes bit 7 of `byte_o` and the eighth becomes bit 0.
- R3: Each complete byte produces exactly one `valid_o` pulse, one system clock long. The pulse appears on the third rising system clock edge after the eighth serial clock rising edge.
- R4: `tag_o` equals the level of `rsel_i` at the eighth serial clock rising edge: 0 for display data, 1 for command. The level of `rsel_i` at earlier bits has no effect.
- R5: Serial clock rising edges while `cs_ni` is high produce no `valid_o` pulse. They also leave no bits behind: the next selected byte is received exactly as sent.
- R6: Raising `cs_ni` in the middle of a byte discards the bits received so far. After reselection, the next eight bits form the next byte.
- R7: Between pulses, `byte_o` and `tag_o` hold the last delivered byte and tag.
- R8: With `cs_ni` held low, consecutive bytes are received back to back. The bit count wraps after every eighth bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 8x the serial clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from host, idles low |
| sdata_i | input | 1 | Serial data, sampled on serial clock rising edge |
| cs_ni | input | 1 | Active-low chip select |
| rsel_i | input | 1 | Register select: 0 display data, 1 command |
| byte_o | output | 8 | Last assembled byte |
| tag_o | output | 1 | Tag of last assembled byte |
| valid_o | output | 1 | One-cycle strobe marking a new byte |

## Verification
Every host line crosses two synchronizer flops. The edge detector compares against one more registered copy of the clock, and the output stage adds one register. So a byte is due on the third system clock edge after its eighth serial clock rising edge.

The bench changes inputs on falling system clock edges. At the last bit it samples on the second falling edge after the serial clock rise and expects no strobe. It then samples on the third and expects the strobe with the byte and tag, and on the fourth and expects the strobe gone. A pulse counter updated on falling edges confirms that exactly one strobe occurred per byte. The same counter confirms that none occurred while deselected.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  // host line positions inside the synchronized bus
  localparam int unsigned IDX_SCLK = 0;
  localparam int unsigned IDX_SDATA = 1;
  localparam int unsigned IDX_CS_N = 2;
  localparam int unsigned IDX_RSEL = 3;
  localparam int unsigned HOST_W = 4;

  typedef enum logic {
    TAG_DATA = 1'b0,
    TAG_CMD  = 1'b1
  } tag_e;
endpackage

// File: rtl/tsr_sync.sv
module tsr_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[0] <= RST_VAL;
          else         stage_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[s] <= RST_VAL;
          else         stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/tsr_edge.sv
module tsr_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_s_i,
  input  logic cs_ns_i,
  output logic rise_o
);
  logic sclk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_prev_q <= 1'b0;
    else         sclk_prev_q <= sclk_s_i;
  end

  // edges seen while deselected are dropped
  assign rise_o = sclk_s_i & ~sclk_prev_q & ~cs_ns_i;
endmodule

// File: rtl/tsr_shift.sv
module tsr_shift #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  input  logic              tag_i,
  output logic [DATA_W-1:0] word_o,
  output logic              tag_o,
  output logic              valid_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_next;
  logic              last_bit;

  assign sh_next  = {sh_q[DATA_W-2:0], bit_i};
  assign last_bit = shift_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (shift_i) begin
      sh_q  <= sh_next;
      cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o  <= '0;
      tag_o   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= last_bit;
      if (last_bit) begin
        word_o <= sh_next;
        tag_o  <= tag_i;
      end
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tagged_serial_rx.sv
module tagged_serial_rx
  import tsr_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              cs_ni,
  input  logic              rsel_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              tag_o,
  output logic              valid_o
);
  localparam logic [HOST_W-1:0] SYNC_RST = HOST_W'(1) << IDX_CS_N;

  logic [HOST_W-1:0] host_raw;
  logic [HOST_W-1:0] host_s;
  logic              sclk_rise;
  logic              cs_s;
  logic [CNT_W-1:0]  bit_cnt;

  always_comb begin
    host_raw            = '0;
    host_raw[IDX_SCLK]  = sclk_i;
    host_raw[IDX_SDATA] = sdata_i;
    host_raw[IDX_CS_N]  = cs_ni;
    host_raw[IDX_RSEL]  = rsel_i;
  end

  tsr_sync #(
    .W       (HOST_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SYNC_RST)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (host_raw),
    .q_o    (host_s)
  );

  assign cs_s = host_s[IDX_CS_N];

  tsr_edge u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_s_i (host_s[IDX_SCLK]),
    .cs_ns_i  (cs_s),
    .rise_o   (sclk_rise)
  );

  tsr_shift #(
    .DATA_W (DATA_W)
  ) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cs_s),
    .shift_i (sclk_rise),
    .bit_i   (host_s[IDX_SDATA]),
    .tag_i   (host_s[IDX_RSEL]),
    .word_o  (byte_o),
    .tag_o   (tag_o),
    .valid_o (valid_o),
    .cnt_o   (bit_cnt)
  );
endmodule

// File: rtl/tagged_serial_rx_chk.sv
module tagged_serial_rx_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_s,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [DATA_W-1:0] byte_o,
  input logic              tag_o,
  input logic              valid_o
);
  // R3: strobe is a single cycle
  p_single_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R2, R8: strobe only after the final bit position
  p_full_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(bit_cnt) == CNT_W'(DATA_W - 1));

  // R5: no strobe follows a deselected cycle
  p_no_strobe_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> !valid_o);

  // R6: deselection empties the bit count
  p_clear_on_cs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> bit_cnt == '0);

  // R7: outputs hold without a strobe
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(byte_o) && $stable(tag_o)));
endmodule

bind tagged_serial_rx tagged_serial_rx_chk #(
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_s    (cs_s),
  .bit_cnt (bit_cnt),
  .byte_o  (byte_o),
  .tag_o   (tag_o),
  .valid_o (valid_o)
);

// File: tb/tagged_serial_rx_tb_top.sv
`timescale 1ns/1ps
module tagged_serial_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       sdata = 1'b0;
  logic       cs_n = 1'b1;
  logic       rsel = 1'b0;
  logic [7:0] byte_q;
  logic       tag_q;
  logic       valid_q;

  int nchk = 0;
  int nfail = 0;
  int vcnt = 0;
  bit done = 1'b0;

  // {tag, byte}
  localparam logic [8:0] VEC [6] = '{9'h0A5, 9'h13C, 9'h000, 9'h1FF, 9'h081, 9'h17E};

  always #4 clk = ~clk;

  tagged_serial_rx dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .sclk_i  (sclk),
    .sdata_i (sdata),
    .cs_ni   (cs_n),
    .rsel_i  (rsel),
    .byte_o  (byte_q),
    .tag_o   (tag_q),
    .valid_o (valid_q)
  );

  always @(negedge clk) if (rst_n && valid_q) vcnt++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  task automatic pulse_bit(input logic d, input logic rs);
    sdata = d; rsel = rs;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
  endtask

  // rsel carries the inverse tag until the last bit, exercising R4
  task automatic send_byte(input logic [7:0] b, input logic rs, input string req);
    int v0;
    v0 = vcnt;
    for (int i = 7; i > 0; i--) pulse_bit(b[i], ~rs);
    sdata = b[0]; rsel = rs;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(valid_q == 1'b0, {req, " R3 early strobe"}, 32'(valid_q), 32'h0);
    @(negedge clk);
    chk(valid_q == 1'b1 && byte_q == b && tag_q == rs, {req, " R2 R4 byte/tag"},
        {22'h0, valid_q, tag_q, byte_q}, {22'h0, 1'b1, rs, b});
    @(negedge clk);
    chk(valid_q == 1'b0 && vcnt - v0 == 1, {req, " R3 single pulse"},
        32'(vcnt - v0), 32'h1);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic select();
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic deselect();
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    int v0;
    repeat (3) @(negedge clk);
    chk(byte_q == 8'h00 && tag_q == 1'b0 && valid_q == 1'b0, "R1 in reset",
        {23'h0, tag_q, byte_q}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(byte_q == 8'h00 && tag_q == 1'b0 && valid_q == 1'b0, "R1 after release",
        {23'h0, tag_q, byte_q}, 32'h0);

    // table walk: one byte per selection
    foreach (VEC[k]) begin
      select();
      send_byte(VEC[k][7:0], VEC[k][8], "R2 table");
      deselect();
    end

    // R7: outputs hold long after the strobe
    repeat (20) @(negedge clk);
    chk(byte_q == VEC[5][7:0] && tag_q == VEC[5][8], "R7 hold",
        {23'h0, tag_q, byte_q}, {23'h0, VEC[5]});

    // R5: clocks while deselected are ignored
    v0 = vcnt;
    for (int i = 0; i < 8; i++) pulse_bit(1'b1, 1'b1);
    repeat (4) @(negedge clk);
    chk(vcnt == v0, "R5 no strobe while deselected", 32'(vcnt - v0), 32'h0);
    chk(byte_q == VEC[5][7:0], "R5 byte untouched", 32'(byte_q), 32'(VEC[5][7:0]));
    select();
    send_byte(8'h5A, 1'b0, "R5 clean after idle clocks");
    deselect();

    // R6: partial byte discarded
    select();
    v0 = vcnt;
    pulse_bit(1'b1, 1'b0);
    pulse_bit(1'b0, 1'b0);
    pulse_bit(1'b1, 1'b0);
    deselect();
    select();
    send_byte(8'h3C, 1'b1, "R6 after partial discard");
    chk(vcnt - v0 == 1, "R6 strobe count", 32'(vcnt - v0), 32'h1);
    deselect();

    // R8: back-to-back bytes in one selection
    select();
    send_byte(8'hC3, 1'b0, "R8 first");
    send_byte(8'h96, 1'b1, "R8 second");
    send_byte(8'h01, 1'b0, "R8 third");
    deselect();

    // R1: asynchronous reset clears outputs
    rst_n = 1'b0;
    #1;
    chk(byte_q == 8'h00 && tag_q == 1'b0 && valid_q == 1'b0, "R1 mid-run reset",
        {23'h0, tag_q, byte_q}, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    select();
    send_byte(8'hE7, 1'b1, "R1 after re-reset");
    deselect();

    finish_run();
  end
endmodule